// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps network time as a 32-bit seconds count paired with a 31-bit binary fraction of a second. The fraction is scaled so that 2^31 counts make exactly one second. Each time the counter ticks, it adds a programmable step to the fraction. When the fraction passes 2^31 it wraps, and the seconds count moves up by one. In coarse mode the counter ticks on every clock. In fine mode a 32-bit rate word is summed every clock into an accumulator, and the counter ticks only when that accumulator carries out. This lets software trim the tick rate to a fraction of the clock frequency.

Software drives the block through a flat register port. It can load an absolute time, or nudge the running time by a signed offset. It can arm an alarm that raises a sticky interrupt once the time reaches or passes a programmed instant. Reading the fraction freezes a copy of the seconds, so that a two-word read of the time is coherent.

Register map (4-bit word address): 0 control, 1 status, 2 step, 3 rate, 4 load/offset seconds, 5 load/offset fraction, 6 alarm seconds, 7 alarm fraction, 8 live fraction (read), 9 captured seconds (read). Control bits: 0 enable, 1 run, 2 fine mode, 3 apply offset, 4 alarm arm. Status bit 0 is the alarm flag.

Top module: `ptp_clock_core`

## Requirements
- R1: After reset every register reads 0, the time is 0 seconds and 0 fraction, and `alarm_irq_o` is low.
- R2: While control enable (bit 0) is 1 and run (bit 1) is 0, the time is loaded on every clock. The seconds come from register 4 and the fraction from bits 30:0 of register 5. Once run is set, counting starts from that loaded value.
- R3: In coarse mode (control bit 2 = 0), with enable and run both set, every clock adds the step register (8 bits) to the fraction. A sum of 2^31 or more wraps by 2^31 and adds one to the seconds.
- R4: In fine mode (control bit 2 = 1), every running clock adds the rate register to a 32-bit accumulator. The counter ticks only on a carry out of bit 31. The accumulator is held at 0 whenever the counter is not running.
- R5: While running, writing control with bit 3 set adds the offset (seconds in register 4, fraction in bits 30:0 of register 5) to the time on the next clock, when register 5 bit 31 is 0. A fraction sum at or above 2^31 carries one into the seconds.
- R6: When register 5 bit 31 is 1, the offset is subtracted instead. A negative fraction borrows one from the seconds and wraps by 2^31.
- R7: Control bit 3 clears itself in the same clock that applies the offset, so the offset is applied exactly once.
- R8: With arm (control bit 4) set, the alarm flag (status bit 0) and `alarm_irq_o` rise once the time is at or past the alarm time (registers 6 and 7), even when the exact alarm value is stepped over.
- R9: The alarm flag stays set after the alarm is disarmed, until software writes 1 to status bit 0. While the alarm is disarmed the flag never sets.
- R10: A read of address 8 captures the seconds at that clock. Address 9 returns the captured seconds, whatever the live seconds have since become.
- R11: With enable at 0 the time holds its value and does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (triggers the seconds capture on address 8) |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| alarm_irq_o | output | 1 | Sticky alarm interrupt |

## Verification
The hardest case to reach from the ports is a time that has to be exact on both sides of the 2^31 fraction boundary: the wrap during counting, the carry on an added offset, and the borrow on a subtracted one. The bench loads a fraction just below the boundary with a zero step, so the time stays still. It then applies each offset once, and reads the result after freezing the counter. For counting, it runs a known number of clocks from a fraction 12 counts below the wrap, and stops the counter with an enable write whose clock edge it has counted. The rate-gated mode uses a rate of 2^30, so ticks fall on every fourth clock and the final fraction can be predicted exactly.

// File: rtl/ptp_clock_pkg.sv
package ptp_clock_pkg;
  typedef enum logic [3:0] {
    A_CTRL    = 4'd0,
    A_STAT    = 4'd1,
    A_STEP    = 4'd2,
    A_RATE    = 4'd3,
    A_OFS_SEC = 4'd4,
    A_OFS_SUB = 4'd5,
    A_ALM_SEC = 4'd6,
    A_ALM_SUB = 4'd7,
    A_NOW_SUB = 4'd8,
    A_CAP_SEC = 4'd9
  } reg_addr_e;

  localparam int CTRL_W    = 5;
  localparam int CTRL_EN   = 0;
  localparam int CTRL_RUN  = 1;
  localparam int CTRL_FINE = 2;
  localparam int CTRL_ADJ  = 3;
  localparam int CTRL_ARM  = 4;
endpackage

// File: rtl/ptp_tick_gen.sv
module ptp_tick_gen #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             fine_i,
  input  logic [ACC_W-1:0] rate_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, rate_i};
  assign tick_o = active_i & (fine_i ? sum[ACC_W] : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (active_i && fine_i) acc_q <= sum[ACC_W-1:0];
    else                        acc_q <= '0;
  end
endmodule

// File: rtl/ptp_time_cnt.sv
module ptp_time_cnt #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int INC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             adj_i,
  input  logic [INC_W-1:0] step_i,
  input  logic [SEC_W-1:0] ofs_sec_i,
  input  logic [SUB_W:0]   ofs_sub_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             adj_done_o
);
  localparam int PAD_W = SUB_W + 1 - INC_W;

  logic [SEC_W-1:0] sec_q;
  logic [SUB_W-1:0] sub_q;
  logic [SUB_W:0]   step_sum, add_sum, sub_dif;
  logic             neg;

  assign neg      = ofs_sub_i[SUB_W];
  assign step_sum = {1'b0, sub_q} + {{PAD_W{1'b0}}, step_i};
  assign add_sum  = {1'b0, sub_q} + {1'b0, ofs_sub_i[SUB_W-1:0]};
  // bit SUB_W of the difference doubles as the borrow
  assign sub_dif  = {1'b0, sub_q} - {1'b0, ofs_sub_i[SUB_W-1:0]};

  assign adj_done_o = en_i & run_i & adj_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (en_i) begin
      if (!run_i) begin
        sec_q <= ofs_sec_i;
        sub_q <= ofs_sub_i[SUB_W-1:0];
      end else if (adj_i) begin
        if (neg) begin
          sub_q <= sub_dif[SUB_W-1:0];
          sec_q <= sec_q - ofs_sec_i - SEC_W'(sub_dif[SUB_W]);
        end else begin
          sub_q <= add_sum[SUB_W-1:0];
          sec_q <= sec_q + ofs_sec_i + SEC_W'(add_sum[SUB_W]);
        end
      end else if (tick_i) begin
        sub_q <= step_sum[SUB_W-1:0];
        sec_q <= sec_q + SEC_W'(step_sum[SUB_W]);
      end
    end
  end

  assign sec_o = sec_q;
  assign sub_o = sub_q;
endmodule

// File: rtl/ptp_alarm_cmp.sv
module ptp_alarm_cmp #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             clr_i,
  input  logic [SEC_W-1:0] now_sec_i,
  input  logic [SUB_W-1:0] now_sub_i,
  input  logic [SEC_W-1:0] alm_sec_i,
  input  logic [SUB_W-1:0] alm_sub_i,
  output logic             flag_o
);
  logic flag_q, reached;

  // at-or-past so a stepped-over value still fires
  assign reached = {now_sec_i, now_sub_i} >= {alm_sec_i, alm_sub_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (clr_i)  flag_q <= 1'b0;
    else             flag_q <= flag_q | (arm_i & reached);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ptp_clock_core.sv
module ptp_clock_core
  import ptp_clock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INC_W  = 8,
  parameter int ACC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              alarm_irq_o
);
  localparam int SEC_W = DATA_W;
  localparam int SUB_W = DATA_W - 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [INC_W-1:0]  step_q;
  logic [ACC_W-1:0]  rate_q;
  logic [SEC_W-1:0]  ofs_sec_q, alm_sec_q, cap_sec_q;
  logic [SUB_W:0]    ofs_sub_q;
  logic [SUB_W-1:0]  alm_sub_q;

  logic [SEC_W-1:0] now_sec;
  logic [SUB_W-1:0] now_sub;
  logic             tick, adj_done, alm_flag, alm_clr, active;
  logic             wr_ctrl;
  logic             unused_wdata;

  assign active  = ctrl_q[CTRL_EN] & ctrl_q[CTRL_RUN];
  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign alm_clr = wr_en_i && (addr_i == A_STAT) && wdata_i[0];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      step_q    <= '0;
      rate_q    <= '0;
      ofs_sec_q <= '0;
      ofs_sub_q <= '0;
      alm_sec_q <= '0;
      alm_sub_q <= '0;
    end else begin
      if (wr_ctrl)       ctrl_q <= wdata_i[CTRL_W-1:0];
      else if (adj_done) ctrl_q[CTRL_ADJ] <= 1'b0;
      if (wr_en_i) begin
        case (addr_i)
          A_STEP:    step_q    <= wdata_i[INC_W-1:0];
          A_RATE:    rate_q    <= wdata_i[ACC_W-1:0];
          A_OFS_SEC: ofs_sec_q <= wdata_i;
          A_OFS_SUB: ofs_sub_q <= wdata_i;
          A_ALM_SEC: alm_sec_q <= wdata_i;
          A_ALM_SUB: alm_sub_q <= wdata_i[SUB_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // seconds snapshot taken when the fraction is read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cap_sec_q <= '0;
    else if (rd_en_i && (addr_i == A_NOW_SUB))   cap_sec_q <= now_sec;
  end

  ptp_tick_gen #(.ACC_W(ACC_W)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .fine_i   (ctrl_q[CTRL_FINE]),
    .rate_i   (rate_q),
    .tick_o   (tick)
  );

  ptp_time_cnt #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_q[CTRL_EN]),
    .run_i      (ctrl_q[CTRL_RUN]),
    .tick_i     (tick),
    .adj_i      (ctrl_q[CTRL_ADJ]),
    .step_i     (step_q),
    .ofs_sec_i  (ofs_sec_q),
    .ofs_sub_i  (ofs_sub_q),
    .sec_o      (now_sec),
    .sub_o      (now_sub),
    .adj_done_o (adj_done)
  );

  ptp_alarm_cmp #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_alm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (ctrl_q[CTRL_ARM]),
    .clr_i     (alm_clr),
    .now_sec_i (now_sec),
    .now_sub_i (now_sub),
    .alm_sec_i (alm_sec_q),
    .alm_sub_i (alm_sub_q),
    .flag_o    (alm_flag)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:    rdata_o = DATA_W'(ctrl_q);
      A_STAT:    rdata_o = DATA_W'(alm_flag);
      A_STEP:    rdata_o = DATA_W'(step_q);
      A_RATE:    rdata_o = DATA_W'(rate_q);
      A_OFS_SEC: rdata_o = ofs_sec_q;
      A_OFS_SUB: rdata_o = ofs_sub_q;
      A_ALM_SEC: rdata_o = alm_sec_q;
      A_ALM_SUB: rdata_o = DATA_W'(alm_sub_q);
      A_NOW_SUB: rdata_o = DATA_W'(now_sub);
      A_CAP_SEC: rdata_o = cap_sec_q;
      default:   rdata_o = '0;
    endcase
  end

  assign alarm_irq_o = alm_flag;
endmodule

// File: rtl/ptp_clock_chk.sv
module ptp_clock_chk #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en,
  input logic             run,
  input logic             adj,
  input logic             arm,
  input logic             clr,
  input logic             irq,
  input logic [SEC_W-1:0] sec,
  input logic [SUB_W-1:0] sub,
  input logic [SEC_W-1:0] alm_sec,
  input logic [SUB_W-1:0] alm_sub,
  input logic             wr_ctrl
);
  logic past_alarm;
  assign past_alarm = {sec, sub} >= {alm_sec, alm_sub};

  p_adj_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && run && adj && !wr_ctrl) |=> !adj);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> ($stable(sec) && $stable(sub)));

  p_fire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm && past_alarm && !clr) |=> irq);

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq && !clr) |=> irq);

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm && !irq) |=> !irq);

  p_sec_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && run && !adj) |=> (sec == $past(sec) || sec == $past(sec) + 1'b1));
endmodule

bind ptp_clock_core ptp_clock_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en      (ctrl_q[0]),
  .run     (ctrl_q[1]),
  .adj     (ctrl_q[3]),
  .arm     (ctrl_q[4]),
  .clr     (alm_clr),
  .irq     (alarm_irq_o),
  .sec     (now_sec),
  .sub     (now_sub),
  .alm_sec (alm_sec_q),
  .alm_sub (alm_sub_q),
  .wr_ctrl (wr_ctrl)
);

// File: tb/sim_ptp_clock_core.sv
module sim_ptp_clock_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        alarm_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] TWO31 = 32'h8000_0000;

  always #10 clk_i = ~clk_i;

  ptp_clock_core u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .alarm_irq_o(alarm_irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge, each spans one rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic load_time(input logic [31:0] s, input logic [31:0] f, input logic [31:0] extra);
    wr(4'd4, s);
    wr(4'd5, f);
    wr(4'd0, 32'h1 | extra);
    wr(4'd0, 32'h3 | extra);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 10; a++) begin
      rd(a[3:0], v);
      chk($sformatf("R1 reg %0d", a), v, 32'h0);
    end
    chk("R1 irq", {31'h0, alarm_irq_o}, 32'h0);
  endtask

  task automatic t_coarse;
    logic [31:0] f, s, f2, s2;
    wr(4'd2, 32'd5);
    load_time(32'd7, TWO31 - 32'd12, 32'h0);
    idle(3);
    wr(4'd0, 32'h0);  // 4 ticks counted
    rd(4'd8, f);
    rd(4'd9, s);
    chk("R3 wrap fraction", f, 32'd8);
    chk("R3 wrap seconds", s, 32'd8);
    idle(5);
    rd(4'd8, f2);
    rd(4'd9, s2);
    chk("R11 frozen fraction", f2, 32'd8);
    chk("R11 frozen seconds", s2, 32'd8);
  endtask

  task automatic t_load;
    logic [31:0] f, s;
    wr(4'd4, 32'd1234);
    wr(4'd5, 32'h8000_0042);  // sign bit ignored on load
    wr(4'd0, 32'h1);
    idle(2);
    rd(4'd8, f);
    rd(4'd9, s);
    chk("R2 load fraction", f, 32'h42);
    chk("R2 load seconds", s, 32'd1234);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_fine;
    logic [31:0] f;
    wr(4'd2, 32'd100);
    wr(4'd3, 32'h4000_0000);
    load_time(32'd0, 32'd0, 32'h4);
    idle(11);
    wr(4'd0, 32'h0);  // 12 running clocks -> 3 carries
    rd(4'd8, f);
    chk("R4 gated ticks", f, 32'd300);
  endtask

  task automatic t_adjust;
    logic [31:0] f, s, c;
    wr(4'd2, 32'd0);
    load_time(32'd10, TWO31 - 32'd100, 32'h0);
    wr(4'd4, 32'd3);
    wr(4'd5, 32'd250);
    wr(4'd0, 32'hB);
    rd(4'd0, c);
    chk("R7 pending before apply", c, 32'hB);
    rd(4'd0, c);
    chk("R7 self clear", c, 32'h3);
    idle(3);
    rd(4'd8, f);
    rd(4'd9, s);  // captured during the fraction read
    chk("R5 add fraction", f, 32'd150);
    chk("R5 add carry seconds", s, 32'd14);
    wr(4'd0, 32'h0);

    load_time(32'd10, 32'd50, 32'h0);
    wr(4'd4, 32'd2);
    wr(4'd5, 32'h8000_0064);
    wr(4'd0, 32'hB);
    idle(3);
    rd(4'd8, f);
    rd(4'd9, s);
    chk("R6 subtract fraction", f, TWO31 - 32'd50);
    chk("R6 subtract borrow seconds", s, 32'd7);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_alarm;
    logic [31:0] v;
    wr(4'd6, 32'd5);
    wr(4'd7, 32'd10);
    wr(4'd2, 32'd7);
    load_time(32'd4, 32'd0, 32'h0);
    idle(4);
    chk("R9 disarmed no flag", {31'h0, alarm_irq_o}, 32'h0);
    wr(4'd0, 32'h0);
    load_time(32'd5, 32'd0, 32'h10);
    chk("R8 not yet", {31'h0, alarm_irq_o}, 32'h0);
    idle(1);
    chk("R8 before alarm time", {31'h0, alarm_irq_o}, 32'h0);
    idle(3);
    chk("R8 stepped-over alarm fires", {31'h0, alarm_irq_o}, 32'h1);
    wr(4'd0, 32'h3);
    idle(2);
    rd(4'd1, v);
    chk("R9 sticky after disarm", v, 32'h1);
    wr(4'd1, 32'h1);
    idle(2);
    chk("R9 cleared by write-one", {31'h0, alarm_irq_o}, 32'h0);
    wr(4'd0, 32'h13);
    idle(2);
    chk("R8 past alarm re-fires", {31'h0, alarm_irq_o}, 32'h1);
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h1);
  endtask

  task automatic t_capture;
    logic [31:0] f, s;
    wr(4'd2, 32'd1);
    load_time(32'd20, TWO31 - 32'd3, 32'h0);
    rd(4'd8, f);
    chk("R10 fraction near wrap", f, TWO31 - 32'd3);
    idle(10);
    rd(4'd9, s);
    chk("R10 coherent seconds", s, 32'd20);
    rd(4'd8, f);
    rd(4'd9, s);
    chk("R10 new capture", s, 32'd21);
    wr(4'd0, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_coarse();
        t_load();
        t_fine();
        t_adjust();
        t_alarm();
        t_capture();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog expired");
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule